// File: doc/BRIEF.md
# Interrupt Priority Claim Arbiter

This block is the claim path of a platform interrupt controller as seen by a single interrupt target. It holds per-source state: a pending flag, a claimed flag and a priority level. It also holds the target's own enable mask and priority threshold. Sources raise requests with single-cycle set pulses. Software-side writes set priorities, the enable mask and the threshold.

A claim request scans every source in one combinational pass and returns the ID of the best eligible source in the same cycle. On the next clock edge that source's pending flag is cleared and its claimed flag is set. A completion carrying a source ID releases the claimed flag. The interrupt line stays high whenever at least one source could be claimed at that moment.

Source flags are packed into 32-bit words, so a source ID is the word index times 32 plus the bit position within the word. ID 0 is reserved and is returned when nothing is eligible.

Top module: `irq_claim_arbiter`

## Requirements
- R1: A source is a candidate only if it is pending, not claimed and enabled in the target's enable mask. Disabled or claimed sources are never returned.
- R2: A candidate is eligible only if its priority is strictly greater than the target threshold. A priority equal to the threshold is not enough.
- R3: When several sources are eligible, the claim returns the one with the largest priority. On equal priority it returns the lowest source ID.
- R4: The claim ID is valid in the same cycle as `claim_i`. At the following edge the winner's pending flag clears and its claimed flag sets, so a second claim does not return it again.
- R5: If no source is eligible, a claim returns ID 0 and leaves all pending and claimed flags unchanged.
- R6: Source 0 is reserved. Set pulses and priority writes addressed to it have no effect, and it is never claimable.
- R7: Flags are held in 32-bit words, and the ID of bit b in word w is w*32+b. For example, bit 1 of word 1 is source 33.
- R8: `irq_o` is high exactly when at least one source is eligible. It reflects each claim, completion, priority, enable or threshold write from the next cycle onward.
- R9: A completion for a source ID clears that source's claimed flag. The source becomes claimable again once it is pending.
- R10: A set pulse on a claimed source sets its pending flag, but the source stays ineligible until it is completed.
- R11: After reset, every pending flag, claimed flag, priority, enable bit and the threshold are 0. `irq_o` is low and claims return 0.
- R12: If a set pulse arrives on the winning source in the same cycle it is claimed, the claim still succeeds and the pending flag remains set afterwards.

Ports: a set pulse and priority writes on source 0 are ignored. The bench runs the top with 48 sources and 3 priority bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| set_pend_i | input | N_SRC | One-cycle set-pending pulse per source |
| prio_we_i | input | 1 | Priority write strobe |
| prio_id_i | input | ID_W | Source addressed by the priority write |
| prio_val_i | input | PRIO_W | Priority value to write |
| en_we_i | input | 1 | Enable mask write strobe |
| en_mask_i | input | N_SRC | New enable mask, bit n enables source n |
| thr_we_i | input | 1 | Threshold write strobe |
| thr_val_i | input | PRIO_W | New threshold |
| claim_i | input | 1 | Claim request |
| claim_id_o | output | ID_W | Claimed source ID, valid with `claim_i`; 0 means none |
| done_i | input | 1 | Completion strobe |
| done_id_i | input | ID_W | Source being completed |
| irq_o | output | 1 | At least one source is eligible |

## Verification
The bench targets equal-priority ties, where a design that keeps the last match instead of the first returns the higher ID. It also targets a priority equal to the threshold, which a non-strict compare would wrongly accept. It checks that a claimed source re-pended before completion stays hidden, since a design that ignores the claimed flag would hand it out twice. A set pulse landing in the same cycle as its own claim must not be lost, and a design that lets the clear win would drop the request. Sources above 31 confirm the word/bit ID arithmetic, and ignored writes to source 0 must never make it claimable.

// File: rtl/irq_claim_pkg.sv
package irq_claim_pkg;
  localparam int unsigned WORD_W = 32;

  function automatic int unsigned words_for(input int unsigned n);
    return (n + WORD_W - 1) / WORD_W;
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_claim_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ID_W   = 5,
  localparam int unsigned N_WORDS = words_for(N_SRC),
  localparam int unsigned TOT     = N_WORDS * WORD_W
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [N_SRC-1:0]                     set_pend_i,
  input  logic                                 prio_we_i,
  input  logic [ID_W-1:0]                      prio_id_i,
  input  logic [PRIO_W-1:0]                    prio_val_i,
  input  logic                                 take_i,
  input  logic [ID_W-1:0]                      take_id_i,
  input  logic                                 done_i,
  input  logic [ID_W-1:0]                      done_id_i,
  output logic [N_WORDS-1:0][WORD_W-1:0]       pend_o,
  output logic [N_WORDS-1:0][WORD_W-1:0]       claimed_o,
  output logic [TOT-1:0][PRIO_W-1:0]           prio_o
);

  for (genvar s = 0; s < TOT; s++) begin : g_src
    if (s == 0 || s >= N_SRC) begin : g_tie
      // reserved ID 0 and padding bits carry no state
      assign pend_o[s/WORD_W][s%WORD_W]    = 1'b0;
      assign claimed_o[s/WORD_W][s%WORD_W] = 1'b0;
      assign prio_o[s]                     = '0;
    end else begin : g_live
      logic              pend_q, claimed_q;
      logic [PRIO_W-1:0] prio_q;
      logic              hit_take, hit_done, hit_prio;

      assign hit_take = take_i    && (take_id_i == ID_W'(s));
      assign hit_done = done_i    && (done_id_i == ID_W'(s));
      assign hit_prio = prio_we_i && (prio_id_i == ID_W'(s));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pend_q    <= 1'b0;
          claimed_q <= 1'b0;
          prio_q    <= '0;
        end else begin
          // a fresh request outranks the clear done by a claim
          if (set_pend_i[s])  pend_q <= 1'b1;
          else if (hit_take)  pend_q <= 1'b0;
          if (hit_take)       claimed_q <= 1'b1;
          else if (hit_done)  claimed_q <= 1'b0;
          if (hit_prio)       prio_q <= prio_val_i;
        end
      end

      assign pend_o[s/WORD_W][s%WORD_W]    = pend_q;
      assign claimed_o[s/WORD_W][s%WORD_W] = claimed_q;
      assign prio_o[s]                     = prio_q;
    end
  end

endmodule

// File: rtl/irq_tgt_cfg.sv
module irq_tgt_cfg
  import irq_claim_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned N_WORDS = words_for(N_SRC),
  localparam int unsigned TOT     = N_WORDS * WORD_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           en_we_i,
  input  logic [N_SRC-1:0]               en_mask_i,
  input  logic                           thr_we_i,
  input  logic [PRIO_W-1:0]              thr_val_i,
  output logic [N_WORDS-1:0][WORD_W-1:0] en_o,
  output logic [PRIO_W-1:0]              thr_o
);

  logic [TOT-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      thr_o <= '0;
    end else begin
      if (en_we_i)  en_q  <= TOT'(en_mask_i);
      if (thr_we_i) thr_o <= thr_val_i;
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/irq_max_search.sv
module irq_max_search
  import irq_claim_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ID_W   = 5,
  localparam int unsigned N_WORDS = words_for(N_SRC),
  localparam int unsigned TOT     = N_WORDS * WORD_W
) (
  input  logic [N_WORDS-1:0][WORD_W-1:0] pend_i,
  input  logic [N_WORDS-1:0][WORD_W-1:0] claimed_i,
  input  logic [N_WORDS-1:0][WORD_W-1:0] en_i,
  input  logic [TOT-1:0][PRIO_W-1:0]     prio_i,
  input  logic [PRIO_W-1:0]              thr_i,
  output logic [ID_W-1:0]                win_id_o,
  output logic                           win_vld_o
);

  logic [PRIO_W-1:0] best_prio;

  always_comb begin
    best_prio = thr_i;
    win_id_o  = '0;
    win_vld_o = 1'b0;
    for (int w = 0; w < int'(N_WORDS); w++) begin
      for (int b = 0; b < int'(WORD_W); b++) begin
        // strict compare keeps the lowest ID on a tie
        if (pend_i[w][b] && !claimed_i[w][b] && en_i[w][b] &&
            (w * WORD_W + b) != 0 && prio_i[w*WORD_W+b] > best_prio) begin
          best_prio = prio_i[w*WORD_W+b];
          win_id_o  = ID_W'(w * WORD_W + b);
          win_vld_o = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/irq_claim_arbiter.sv
module irq_claim_arbiter
  import irq_claim_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned ID_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned N_WORDS = words_for(N_SRC),
  localparam int unsigned TOT     = N_WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  set_pend_i,
  input  logic              prio_we_i,
  input  logic [ID_W-1:0]   prio_id_i,
  input  logic [PRIO_W-1:0] prio_val_i,
  input  logic              en_we_i,
  input  logic [N_SRC-1:0]  en_mask_i,
  input  logic              thr_we_i,
  input  logic [PRIO_W-1:0] thr_val_i,
  input  logic              claim_i,
  output logic [ID_W-1:0]   claim_id_o,
  input  logic              done_i,
  input  logic [ID_W-1:0]   done_id_i,
  output logic              irq_o
);

  logic [N_WORDS-1:0][WORD_W-1:0] pend_w, claimed_w, en_w;
  logic [TOT-1:0][PRIO_W-1:0]     prio_w;
  logic [PRIO_W-1:0]              thr_w;
  logic [ID_W-1:0]                win_id;
  logic                           win_vld, take;
  logic [TOT-1:0]                 pend_flat, claimed_flat, en_flat;

  assign take       = claim_i && win_vld;
  assign claim_id_o = claim_i ? win_id : '0;
  assign irq_o      = win_vld;

  irq_src_bank #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_bank (
    .clk_i, .rst_ni, .set_pend_i,
    .prio_we_i, .prio_id_i, .prio_val_i,
    .take_i(take), .take_id_i(win_id),
    .done_i, .done_id_i,
    .pend_o(pend_w), .claimed_o(claimed_w), .prio_o(prio_w)
  );

  irq_tgt_cfg #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_cfg (
    .clk_i, .rst_ni, .en_we_i, .en_mask_i, .thr_we_i, .thr_val_i,
    .en_o(en_w), .thr_o(thr_w)
  );

  irq_max_search #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_search (
    .pend_i(pend_w), .claimed_i(claimed_w), .en_i(en_w), .prio_i(prio_w),
    .thr_i(thr_w), .win_id_o(win_id), .win_vld_o(win_vld)
  );

  assign pend_flat    = pend_w;
  assign claimed_flat = claimed_w;
  assign en_flat      = en_w;

  // R1 R2
  winner_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_i && claim_id_o != '0) |->
      (pend_flat[claim_id_o] && !claimed_flat[claim_id_o] &&
       en_flat[claim_id_o] && prio_w[claim_id_o] > thr_w));

  // R4
  claim_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_i && claim_id_o != '0) |=> claimed_flat[$past(claim_id_o)]);

  // R4 R12
  claim_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_i && claim_id_o != '0 && !set_pend_i[claim_id_o]) |=>
      !pend_flat[$past(claim_id_o)]);

  // R5
  idle_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_i && claim_id_o == '0 && !done_i) |=> $stable(claimed_flat));

  // R9
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && 32'(done_id_i) < TOT && !(claim_i && claim_id_o == done_id_i)) |=>
      !claimed_flat[$past(done_id_i)]);

  // R6
  src0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_flat[0] && !claimed_flat[0]);

  // R2
  thr_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_w == '1) |-> !irq_o);

endmodule

// File: tb/irq_claim_arbiter_test.sv
module irq_claim_arbiter_test;
  localparam int N  = 48;
  localparam int PW = 3;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  set_pend = '0;
  logic          prio_we = 1'b0;
  logic [IW-1:0] prio_id = '0;
  logic [PW-1:0] prio_val = '0;
  logic          en_we = 1'b0;
  logic [N-1:0]  en_mask = '0;
  logic          thr_we = 1'b0;
  logic [PW-1:0] thr_val = '0;
  logic          claim = 1'b0;
  logic [IW-1:0] claim_id;
  logic          done = 1'b0;
  logic [IW-1:0] done_id = '0;
  logic          irq;

  int checks = 0;
  int failures = 0;
  int q_id[$];
  string q_tag[$];

  always #5 clk = ~clk;

  irq_claim_arbiter #(.N_SRC(N), .PRIO_W(PW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .set_pend_i(set_pend),
    .prio_we_i(prio_we), .prio_id_i(prio_id), .prio_val_i(prio_val),
    .en_we_i(en_we), .en_mask_i(en_mask), .thr_we_i(thr_we), .thr_val_i(thr_val),
    .claim_i(claim), .claim_id_o(claim_id), .done_i(done), .done_id_i(done_id),
    .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compares claim results against the scoreboard queue
  always @(negedge clk) begin
    #2;
    if (rst_n && claim) begin
      if (q_id.size() == 0) chk(1'b0, "scoreboard underflow", int'(claim_id), -1);
      else begin
        int e;
        string t;
        e = q_id.pop_front();
        t = q_tag.pop_front();
        chk(int'(claim_id) == e, t, int'(claim_id), e);
      end
    end
  end

  task automatic do_claim(input int exp, input string tag);
    @(negedge clk);
    claim = 1'b1;
    q_id.push_back(exp);
    q_tag.push_back(tag);
    @(negedge clk);
    claim = 1'b0;
  endtask

  task automatic claim_with_set(input int src, input int exp, input string tag);
    @(negedge clk);
    claim = 1'b1;
    set_pend[src] = 1'b1;
    q_id.push_back(exp);
    q_tag.push_back(tag);
    @(negedge clk);
    claim = 1'b0;
    set_pend = '0;
  endtask

  task automatic pend(input logic [N-1:0] m);
    @(negedge clk); set_pend = m;
    @(negedge clk); set_pend = '0;
  endtask

  task automatic wr_prio(input int id, input int v);
    @(negedge clk); prio_we = 1'b1; prio_id = IW'(id); prio_val = PW'(v);
    @(negedge clk); prio_we = 1'b0;
  endtask

  task automatic wr_en(input logic [N-1:0] m);
    @(negedge clk); en_we = 1'b1; en_mask = m;
    @(negedge clk); en_we = 1'b0;
  endtask

  task automatic wr_thr(input int v);
    @(negedge clk); thr_we = 1'b1; thr_val = PW'(v);
    @(negedge clk); thr_we = 1'b0;
  endtask

  task automatic complete(input int id);
    @(negedge clk); done = 1'b1; done_id = IW'(id);
    @(negedge clk); done = 1'b0;
  endtask

  task automatic chk_irq(input bit exp, input string tag);
    #2;
    chk(irq == exp, tag, int'(irq), int'(exp));
  endtask

  function automatic logic [N-1:0] bits(input int a, input int b = 0,
                                       input int c = 0, input int d = 0);
    logic [N-1:0] m = '0;
    m[a] = 1'b1;
    if (b != 0) m[b] = 1'b1;
    if (c != 0) m[c] = 1'b1;
    if (d != 0) m[d] = 1'b1;
    return m;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_irq(1'b0, "R11 irq low after reset");
    do_claim(0, "R11 R5 claim after reset returns 0");

    wr_en('1);
    pend(bits(2));
    chk_irq(1'b0, "R11 reset priority 0 not eligible");

    wr_prio(3, 2); wr_prio(5, 5); wr_prio(9, 5); wr_prio(40, 6);
    pend(bits(3, 5, 9));
    chk_irq(1'b1, "R8 irq high with eligible sources");
    do_claim(5, "R3 tie goes to lowest ID");
    do_claim(9, "R4 previous winner now claimed");
    do_claim(3, "R3 lowest priority last");
    do_claim(0, "R5 nothing eligible");
    chk_irq(1'b0, "R8 irq low after last claim");

    complete(3); complete(5); complete(9);
    pend(bits(3, 5, 9, 40));
    wr_thr(5);
    do_claim(40, "R7 word 1 source wins above threshold");
    do_claim(0, "R2 priority equal to threshold rejected");
    chk_irq(1'b0, "R2 irq low at threshold");
    wr_thr(4);
    chk_irq(1'b1, "R8 irq after threshold write");
    do_claim(5, "R2 R3 above lowered threshold");

    wr_en('1 & ~bits(9));
    do_claim(0, "R1 disabled source skipped");
    wr_thr(0);
    chk_irq(1'b1, "R8 irq after threshold lowered");
    do_claim(3, "R1 enabled source chosen over disabled");
    do_claim(0, "R1 only disabled source pending");

    pend(bits(5));
    chk_irq(1'b0, "R10 re-pended claimed source hidden");
    do_claim(0, "R10 claimed source not returned");
    complete(5);
    chk_irq(1'b1, "R9 irq after completion");
    do_claim(5, "R9 completed source claimable again");

    pend(bits(0));
    wr_prio(0, 7);
    do_claim(0, "R6 source 0 never claimable");
    chk_irq(1'b0, "R6 irq stays low");

    wr_prio(7, 3);
    pend(bits(7));
    claim_with_set(7, 7, "R12 claim with concurrent set");
    chk_irq(1'b0, "R12 claimed source hidden");
    complete(7);
    chk_irq(1'b1, "R12 pending kept after concurrent set");
    do_claim(7, "R12 source reclaimed");
    do_claim(0, "R12 nothing left");

    pend(bits(12));
    chk_irq(1'b0, "R8 priority 0 pending source");
    wr_prio(12, 1);
    chk_irq(1'b1, "R8 irq after priority write");
    do_claim(12, "R8 claim after priority write");

    wr_prio(33, 4);
    pend(bits(33));
    do_claim(33, "R7 word 1 bit 1 is ID 33");

    repeat (2) @(negedge clk);
    chk(q_id.size() == 0, "scoreboard drained", q_id.size(), 0);
    finish_run();
  end

endmodule